// File: doc/BRIEF.md
# Shared RAM Slice Mapping Unit

A shared work RAM is cut into equal slices, and each slice can be handed to one of several bus masters at a chosen window position in that master's address view. This unit holds one configuration byte per slice. Software loads them through a 32-bit register write port with byte enables. Each master's address decoder then asks the unit which physical slice, if any, sits behind a given window.

The parameter `VARIANT` selects between two bank types. Variant 0 has 4 slices and serves 2 masters with 4 windows each. Variant 1, the default, has 8 slices and serves 3 masters with 8 windows each. The two variants decode the configuration byte differently.

The unit rebuilds the mapping every cycle from the full set of configuration bytes. When several enabled slices claim the same window, a fixed slice-number priority picks the owner, so the order in which software wrote the registers has no effect.

Top module: `slice_map_unit`

## Requirements
- R1: During reset every configuration byte is cleared to 0x00. In the cycle after reset, every lookup misses.
- R2: The configuration byte of slice n is stored in byte lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of register n div 4. A write changes only the byte lanes whose `wr_be` bit is 1.
- R3: Bit 7 of a configuration byte enables its slice. A slice with bit 7 at 0 is not mapped to any master or window.
- R4: In variant 1, bits 4:2 give the window and bits 1:0 give the master. Master code 3 is treated as master 2. A lookup with master 3 always misses.
- R5: In variant 0, bits 3:2 give the window and bit 0 gives the master. Bits 1 and 6:4 are ignored. A lookup with master 2 or 3 misses.
- R6: When two or more enabled slices claim the same master and window, the slice with the lowest number wins, whatever the order of the writes.
- R7: A lookup that no enabled slice claims returns `lk_hit` = 0 and `lk_slice` = 0.
- R8: The lookup port is combinational on the stored bytes. A write takes effect at the clock edge that accepts it, and lookups show the new mapping from then on, not before.
- R9: The mapping is rebuilt from all bytes after any change. When the owner of a window is disabled or moved, the next-lowest enabled claimant of that window takes it over.
- R10: A write whose `wr_idx` is at or above the register count has no effect. The register count is 1 in variant 0 and 2 in variant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index |
| wr_data | input | 32 | Write data, four configuration bytes |
| wr_be | input | 4 | Byte-lane enables |
| lk_master | input | 2 | Lookup master ID |
| lk_window | input | 2 (variant 0) / 3 (variant 1) | Lookup window index |
| lk_hit | output | 1 | A slice is mapped at this master and window |
| lk_slice | output | 2 (variant 0) / 3 (variant 1) | Number of the mapped slice, 0 on a miss |

## Verification
A register write and a lookup of the window that the write affects can fall in the same cycle. The bench provokes this by holding a write on the port and looking up the window it targets before the accepting clock edge. It expects the old answer before the edge and the new one after it. It also writes a claimant that outranks the current owner, and one that is outranked by it, and checks which slice the lookup reports immediately after each edge. That shows the priority is settled within the same cycle as the write and does not depend on when each slice was written.

// File: rtl/smu_pkg.sv
package smu_pkg;

  typedef struct packed {
    logic       en;
    logic [1:0] mst;
    logic [2:0] win;
  } slice_cfg_t;

  function automatic int num_slices(input int v);
    return (v == 0) ? 4 : 8;
  endfunction

  function automatic int num_masters(input int v);
    return (v == 0) ? 2 : 3;
  endfunction

  function automatic int num_windows(input int v);
    return (v == 0) ? 4 : 8;
  endfunction

  function automatic int win_w(input int v);
    return (v == 0) ? 2 : 3;
  endfunction

  function automatic int slice_w(input int v);
    return (v == 0) ? 2 : 3;
  endfunction

endpackage

// File: rtl/smu_cfg_store.sv
module smu_cfg_store #(
  parameter int NUM_REGS  = 2,
  parameter int REG_IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [REG_IDX_W-1:0]     wr_idx,
  input  logic [31:0]              wr_data,
  input  logic [3:0]               wr_be,
  output logic [NUM_REGS*32-1:0]   cfg_flat
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < 4; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lane_q <= 8'h00;
        end else if (wr_en && wr_be[b] && (wr_idx == REG_IDX_W'(r))) begin
          lane_q <= wr_data[b*8 +: 8];
        end
      end
      assign cfg_flat[r*32 + b*8 +: 8] = lane_q;
    end
  end

endmodule

// File: rtl/smu_slice_decode.sv
module smu_slice_decode
  import smu_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic [7:0]  cfg_byte,
  output slice_cfg_t  dec
);

  if (VARIANT == 0) begin : g_small
    logic unused_bits;
    assign unused_bits = ^{cfg_byte[6:4], cfg_byte[1]};
    assign dec.en  = cfg_byte[7];
    assign dec.mst = {1'b0, cfg_byte[0]};
    assign dec.win = {1'b0, cfg_byte[3:2]};
  end else begin : g_large
    logic unused_bits;
    assign unused_bits = ^cfg_byte[6:5];
    assign dec.en  = cfg_byte[7];
    assign dec.mst = cfg_byte[1] ? 2'd2 : {1'b0, cfg_byte[0]};
    assign dec.win = cfg_byte[4:2];
  end

endmodule

// File: rtl/smu_resolver.sv
module smu_resolver
  import smu_pkg::*;
#(
  parameter int NUM_SLICES  = 8,
  parameter int NUM_MASTERS = 3,
  parameter int NUM_WINDOWS = 8,
  parameter int SLICE_W     = 3,
  localparam int ENTRIES    = NUM_MASTERS * NUM_WINDOWS
) (
  input  slice_cfg_t         dec     [NUM_SLICES],
  output logic               hit_tab [ENTRIES],
  output logic [SLICE_W-1:0] sl_tab  [ENTRIES]
);

  // Highest slice first, so lower numbers overwrite and win.
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      hit_tab[e] = 1'b0;
      sl_tab[e]  = '0;
      for (int s = NUM_SLICES - 1; s >= 0; s--) begin
        if (dec[s].en &&
            dec[s].mst == 2'(e / NUM_WINDOWS) &&
            dec[s].win == 3'(e % NUM_WINDOWS)) begin
          hit_tab[e] = 1'b1;
          sl_tab[e]  = SLICE_W'(s);
        end
      end
    end
  end

endmodule

// File: rtl/slice_map_unit.sv
module slice_map_unit
  import smu_pkg::*;
#(
  parameter int VARIANT   = 1,
  parameter int REG_IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [REG_IDX_W-1:0]          wr_idx,
  input  logic [31:0]                   wr_data,
  input  logic [3:0]                    wr_be,
  input  logic [1:0]                    lk_master,
  input  logic [win_w(VARIANT)-1:0]     lk_window,
  output logic                          lk_hit,
  output logic [slice_w(VARIANT)-1:0]   lk_slice
);

  localparam int NUM_SLICES  = num_slices(VARIANT);
  localparam int NUM_MASTERS = num_masters(VARIANT);
  localparam int NUM_WINDOWS = num_windows(VARIANT);
  localparam int WIN_W       = win_w(VARIANT);
  localparam int SLICE_W     = slice_w(VARIANT);
  localparam int NUM_REGS    = NUM_SLICES / 4;
  localparam int ENTRIES     = NUM_MASTERS * NUM_WINDOWS;

  logic [NUM_REGS*32-1:0] cfg_q;
  slice_cfg_t             dec     [NUM_SLICES];
  logic                   hit_tab [ENTRIES];
  logic [SLICE_W-1:0]     sl_tab  [ENTRIES];

  smu_cfg_store #(
    .NUM_REGS  (NUM_REGS),
    .REG_IDX_W (REG_IDX_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .cfg_flat (cfg_q)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_dec
    smu_slice_decode #(.VARIANT(VARIANT)) u_dec (
      .cfg_byte (cfg_q[s*8 +: 8]),
      .dec      (dec[s])
    );
  end

  smu_resolver #(
    .NUM_SLICES  (NUM_SLICES),
    .NUM_MASTERS (NUM_MASTERS),
    .NUM_WINDOWS (NUM_WINDOWS),
    .SLICE_W     (SLICE_W)
  ) u_res (
    .dec     (dec),
    .hit_tab (hit_tab),
    .sl_tab  (sl_tab)
  );

  always_comb begin
    lk_hit   = 1'b0;
    lk_slice = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_master == 2'(e / NUM_WINDOWS) &&
          lk_window == WIN_W'(e % NUM_WINDOWS)) begin
        lk_hit   = hit_tab[e];
        lk_slice = sl_tab[e];
      end
    end
  end

endmodule

// File: rtl/slice_map_unit_chk.sv
module slice_map_unit_chk #(
  parameter int NUM_REGS    = 2,
  parameter int NUM_MASTERS = 3,
  parameter int SLICE_W     = 3,
  parameter int REG_IDX_W   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [REG_IDX_W-1:0]   wr_idx,
  input logic [1:0]             lk_master,
  input logic                   lk_hit,
  input logic [SLICE_W-1:0]     lk_slice,
  input logic [NUM_REGS*32-1:0] cfg_q
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !lk_hit);

  p_hit_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> cfg_q[{lk_slice, 3'b111}]);

  p_bad_master_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_master) >= NUM_MASTERS) |-> !lk_hit);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_slice == '0));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q));

  p_bad_index_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_idx) >= NUM_REGS) |=> $stable(cfg_q));

endmodule

bind slice_map_unit slice_map_unit_chk #(
  .NUM_REGS    (NUM_REGS),
  .NUM_MASTERS (NUM_MASTERS),
  .SLICE_W     (SLICE_W),
  .REG_IDX_W   (REG_IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .lk_master (lk_master),
  .lk_hit    (lk_hit),
  .lk_slice  (lk_slice),
  .cfg_q     (cfg_q)
);

// File: tb/slice_map_unit_tb.sv
module slice_map_unit_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  // variant 1 (default) signals
  logic        b_wr_en = 1'b0;
  logic [1:0]  b_idx = '0;
  logic [31:0] b_data = '0;
  logic [3:0]  b_be = '0;
  logic [1:0]  b_m = '0;
  logic [2:0]  b_w = '0;
  logic        b_hit;
  logic [2:0]  b_sl;

  // variant 0 signals
  logic        a_wr_en = 1'b0;
  logic [1:0]  a_idx = '0;
  logic [31:0] a_data = '0;
  logic [3:0]  a_be = '0;
  logic [1:0]  a_m = '0;
  logic [1:0]  a_w = '0;
  logic        a_hit;
  logic [1:0]  a_sl;

  slice_map_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(b_wr_en), .wr_idx(b_idx), .wr_data(b_data),
    .wr_be(b_be), .lk_master(b_m), .lk_window(b_w), .lk_hit(b_hit), .lk_slice(b_sl)
  );

  slice_map_unit #(.VARIANT(0)) u_dut_a (
    .clk(clk), .rst(rst), .wr_en(a_wr_en), .wr_idx(a_idx), .wr_data(a_data),
    .wr_be(a_be), .lk_master(a_m), .lk_window(a_w), .lk_hit(a_hit), .lk_slice(a_sl)
  );

  task automatic wr_b(input logic [1:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    b_wr_en = 1'b1; b_idx = idx; b_data = d; b_be = be;
    @(negedge clk);
    b_wr_en = 1'b0;
  endtask

  task automatic wr_a(input logic [1:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    a_wr_en = 1'b1; a_idx = idx; a_data = d; a_be = be;
    @(negedge clk);
    a_wr_en = 1'b0;
  endtask

  task automatic chk_b(input int m, input int w, input int eh, input int es, input string tag);
    b_m = 2'(m); b_w = 3'(w);
    #1;
    nchk++;
    if (b_hit !== 1'(eh) || b_sl !== 3'(es)) begin
      nerr++;
      $display("FAIL %s: v1 m=%0d w=%0d got hit=%0b slice=%0d expected hit=%0d slice=%0d",
               tag, m, w, b_hit, b_sl, eh, es);
    end
  endtask

  task automatic chk_a(input int m, input int w, input int eh, input int es, input string tag);
    a_m = 2'(m); a_w = 2'(w);
    #1;
    nchk++;
    if (a_hit !== 1'(eh) || a_sl !== 2'(es)) begin
      nerr++;
      $display("FAIL %s: v0 m=%0d w=%0d got hit=%0b slice=%0d expected hit=%0d slice=%0d",
               tag, m, w, a_hit, a_sl, eh, es);
    end
  endtask

  task automatic t_reset;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 8; w++) chk_b(m, w, 0, 0, "R1 reset v1");
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++) chk_a(m, w, 0, 0, "R1 reset v0");
  endtask

  task automatic t_decode_b;
    // slice0 = 0x95 -> master1 win5; slice1 = 0x8F -> code3 as master2 win3
    wr_b(2'd0, 32'h0000_8F95, 4'b0011);
    chk_b(1, 5, 1, 0, "R4 window bits");
    chk_b(1, 4, 0, 0, "R7 unclaimed window");
    chk_b(2, 3, 1, 1, "R4 code3 as master2");
    chk_b(3, 3, 0, 0, "R4 master3 misses");
  endtask

  task automatic t_byte_enable;
    wr_b(2'd0, 32'hFFFF_FFFF, 4'b0000);
    chk_b(1, 5, 1, 0, "R2 no lanes enabled");
    chk_b(2, 7, 0, 0, "R2 no lanes enabled");
    wr_b(2'd0, 32'hFFFF_FFFF, 4'b0100);
    chk_b(2, 7, 1, 2, "R2 lane2 is slice2");
    chk_b(1, 5, 1, 0, "R2 lane0 kept");
    wr_b(2'd0, 32'h0000_0000, 4'b0100);
    chk_b(2, 7, 0, 0, "R3 cleared slice unmapped");
  endtask

  task automatic t_priority;
    wr_b(2'd1, 32'h009C_0000, 4'b0100);
    chk_b(0, 7, 1, 6, "R2 slice6 in reg1 lane2");
    wr_b(2'd1, 32'h9C00_0000, 4'b1000);
    chk_b(0, 7, 1, 6, "R6 later higher slice loses");
    wr_b(2'd0, 32'h009C_0000, 4'b0100);
    chk_b(0, 7, 1, 2, "R6 lower slice wins");
    wr_b(2'd0, 32'h001C_0000, 4'b0100);
    chk_b(0, 7, 1, 6, "R3 R9 disabled owner falls back");
    wr_b(2'd1, 32'h0000_0000, 4'b0100);
    chk_b(0, 7, 1, 7, "R9 next claimant takes over");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    b_wr_en = 1'b1; b_idx = 2'd1; b_data = 32'h0000_0082; b_be = 4'b0001;
    chk_b(2, 0, 0, 0, "R8 not visible before edge");
    @(negedge clk);
    b_wr_en = 1'b0;
    chk_b(2, 0, 1, 4, "R8 visible after edge");
  endtask

  task automatic t_bad_index;
    wr_b(2'd2, 32'hFFFF_FFFF, 4'b1111);
    wr_b(2'd3, 32'hFFFF_FFFF, 4'b1111);
    chk_b(2, 0, 1, 4, "R10 reg1 untouched");
    chk_b(0, 7, 1, 7, "R10 reg1 untouched");
    chk_b(1, 5, 1, 0, "R10 reg0 untouched");
    chk_b(2, 7, 0, 0, "R10 no wrap into reg0");
  endtask

  task automatic t_variant_a;
    // slice0 0x8B -> master1 win2; slice1 and slice3 0x94 -> master0 win1
    wr_a(2'd0, 32'h9400_948B, 4'b1011);
    chk_a(1, 2, 1, 0, "R5 bit1 ignored");
    chk_a(0, 1, 1, 1, "R5 R6 bit4 ignored, slice1 wins");
    chk_a(2, 2, 0, 0, "R5 master2 misses");
    chk_a(1, 3, 0, 0, "R7 unclaimed v0");
    wr_a(2'd0, 32'h0000_0000, 4'b0010);
    chk_a(0, 1, 1, 3, "R9 slice3 takes over");
    wr_a(2'd1, 32'hFFFF_FFFF, 4'b1111);
    chk_a(1, 2, 1, 0, "R10 v0 index1 ignored");
    chk_a(1, 3, 0, 0, "R10 v0 no wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode_b();
    t_byte_enable();
    t_priority();
    t_same_cycle();
    t_bad_index();
    t_variant_a();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule